// File: doc/BRIEF.md
# JTAG Debug Port Scan Chain

This block is the target end of a JTAG debug port. A host clocks it through TCK, TMS and TDI and reads TDO. A standard sixteen-state TAP controller sequences a 4-bit instruction register and a bank of data registers. The selectable data registers are a 1-bit bypass stage, a 32-bit identification register and a 35-bit access register. The access register works in three roles: debug-port access, access-port access and abort.

The access register is asymmetric. On the way in, it carries a 32-bit data word, a 2-bit register address and a read/write flag. On capture, it loads the previous read result and a 3-bit acknowledge, which then shift out. When Update-DR completes, the block presents a one-cycle request strobe on its parallel side. The strobe carries data, address, direction and a flag that tells debug port from access port. An abort scan with its lowest bit set raises a one-cycle abort pulse instead. Every instruction code the block does not implement, boundary-scan codes included, selects the bypass stage.

The whole block runs on TCK with an asynchronous active-low test reset. TDO is launched on the falling edge of TCK.

Top module: `dbg_scan_port`

## Requirements
- R1: After the test reset, or after five consecutive TCK rising edges with TMS high from any TAP state, the controller is in Test-Logic-Reset and the instruction register holds the identification opcode 4'b1110. The first data scan then reads the identification value.
- R2: The identification register (opcode 4'b1110) is 32 bits long and captures 32'h3BA00477. It shifts out LSB first. Its fields are version [31:28]=3, part [27:12]=16'hBA00, maker [11:1]=11'h23B and bit 0 = 1.
- R3: The instruction register is 4 bits long and captures 4'b0001, so TDO gives 1,0,0,0 during an IR shift. The new opcode takes effect on Update-IR.
- R4: Opcode 4'b1111, and every opcode other than 1110, 1010, 1011 and 1000, selects a 1-bit bypass stage that captures 0. TDI reappears on TDO one shift later.
- R5: Opcodes 4'b1010 (debug port) and 4'b1011 (access port) select a 35-bit register, shifted in LSB first. Bit [0] is the read flag (1 = read), bits [2:1] are the address and bits [34:3] are the data. On leaving Update-DR, req_valid is high for exactly one TCK cycle, with req_ap=0 for the debug port and 1 for the access port.
- R6: On Capture-DR, with port_busy low, the access register loads resp_data into [34:3] and resp_ack into [2:0]. The acknowledge code for OK/FAULT is 3'b010.
- R7: If port_busy is high at Capture-DR, the acknowledge field captures WAIT (3'b001) and the following Update-DR issues no request.
- R8: A debug-port write (read flag 0) to address 2'b00 issues no request. A debug-port read of address 2'b00 is still forwarded.
- R9: Opcode 4'b1000 selects the 35-bit abort register, which captures zero. An update with bit [0]=1 gives a one-cycle abort_pulse whatever bits [34:1] hold. An update with bit [0]=0 gives none.
- R10: TDO changes only on the falling edge of TCK and is 0 outside Shift-DR and Shift-IR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock; the whole block runs on it |
| trst_n | input | 1 | Asynchronous active-low test reset |
| tms | input | 1 | Test mode select |
| tdi | input | 1 | Serial data in, sampled on the rising edge |
| tdo | output | 1 | Serial data out, launched on the falling edge |
| req_valid | output | 1 | One-cycle strobe for an access request |
| req_ap | output | 1 | 1 = access-port request, 0 = debug-port request |
| req_addr | output | 2 | Register address of the request |
| req_rnw | output | 1 | 1 = read, 0 = write |
| req_data | output | 32 | Write data of the request |
| port_busy | input | 1 | Port cannot take a request; capture reports WAIT |
| resp_data | input | 32 | Result of the previous read |
| resp_ack | input | 3 | Acknowledge for the previous access |
| abort_pulse | output | 1 | One-cycle abort request |

## Verification
On every cycle, assertions check the following: five TMS-high edges always land in Test-Logic-Reset, the IR and identification captures load their fixed values, a busy capture loads WAIT, and request and abort strobes last one cycle and follow Update-DR. The bench scenarios cover the rest. They measure the length of the selected register for all sixteen opcodes. They check the field positions of issued requests and the dropped write to the reserved debug-port address, and they test abort with reserved bits set and cleared.

// File: rtl/dbg_scan_pkg.sv
package dbg_scan_pkg;

   typedef enum logic [3:0] {
      ST_TLR, ST_RTI,
      ST_SEL_DR, ST_CAP_DR, ST_SH_DR, ST_EX1_DR, ST_PA_DR, ST_EX2_DR, ST_UPD_DR,
      ST_SEL_IR, ST_CAP_IR, ST_SH_IR, ST_EX1_IR, ST_PA_IR, ST_EX2_IR, ST_UPD_IR
   } tap_state_t;

   localparam logic [2:0] ACK_OK   = 3'b010;
   localparam logic [2:0] ACK_WAIT = 3'b001;

endpackage

// File: rtl/dbg_tap_fsm.sv
module dbg_tap_fsm
   import dbg_scan_pkg::*;
(
   input  logic       tck,
   input  logic       trst_n,
   input  logic       tms,
   output tap_state_t state
);

   tap_state_t nxt;

   always_comb begin
      case (state)
         ST_TLR:    nxt = tms ? ST_TLR    : ST_RTI;
         ST_RTI:    nxt = tms ? ST_SEL_DR : ST_RTI;
         ST_SEL_DR: nxt = tms ? ST_SEL_IR : ST_CAP_DR;
         ST_CAP_DR: nxt = tms ? ST_EX1_DR : ST_SH_DR;
         ST_SH_DR:  nxt = tms ? ST_EX1_DR : ST_SH_DR;
         ST_EX1_DR: nxt = tms ? ST_UPD_DR : ST_PA_DR;
         ST_PA_DR:  nxt = tms ? ST_EX2_DR : ST_PA_DR;
         ST_EX2_DR: nxt = tms ? ST_UPD_DR : ST_SH_DR;
         ST_UPD_DR: nxt = tms ? ST_SEL_DR : ST_RTI;
         ST_SEL_IR: nxt = tms ? ST_TLR    : ST_CAP_IR;
         ST_CAP_IR: nxt = tms ? ST_EX1_IR : ST_SH_IR;
         ST_SH_IR:  nxt = tms ? ST_EX1_IR : ST_SH_IR;
         ST_EX1_IR: nxt = tms ? ST_UPD_IR : ST_PA_IR;
         ST_PA_IR:  nxt = tms ? ST_EX2_IR : ST_PA_IR;
         ST_EX2_IR: nxt = tms ? ST_UPD_IR : ST_SH_IR;
         ST_UPD_IR: nxt = tms ? ST_SEL_DR : ST_RTI;
         default:   nxt = ST_TLR;
      endcase
   end

   always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n) state <= ST_TLR;
      else         state <= nxt;
   end

   // run length of TMS-high edges, saturating, for the reset-path check
   logic [2:0] hi_run;
   always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n)           hi_run <= '0;
      else if (!tms)         hi_run <= '0;
      else if (hi_run != 3'd7) hi_run <= hi_run + 3'd1;
   end

   a_r1_five_high_resets: assert property (@(posedge tck) disable iff (!trst_n)
      (hi_run >= 3'd5) |-> (state == ST_TLR));

endmodule

// File: rtl/dbg_ir_stage.sv
module dbg_ir_stage
   import dbg_scan_pkg::*;
#(
   parameter int          IR_W     = 4,
   parameter logic [IR_W-1:0] RESET_OP = 4'b1110
)(
   input  logic            tck,
   input  logic            trst_n,
   input  tap_state_t      state,
   input  logic            tdi,
   output logic [IR_W-1:0] ir,
   output logic            ir_tdo
);

   localparam logic [IR_W-1:0] CAP_VAL = {{(IR_W-1){1'b0}}, 1'b1};

   logic [IR_W-1:0] ir_sh;

   initial begin : p_param_chk
      assert (IR_W >= 2) else $error("IR_W must be at least 2");
   end

   always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n) begin
         ir_sh <= '0;
      end else begin
         case (state)
            ST_CAP_IR: ir_sh <= CAP_VAL;
            ST_SH_IR:  ir_sh <= {tdi, ir_sh[IR_W-1:1]};
            default:   ir_sh <= ir_sh;
         endcase
      end
   end

   always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n)                ir <= RESET_OP;
      else if (state == ST_TLR)   ir <= RESET_OP;
      else if (state == ST_UPD_IR) ir <= ir_sh;
   end

   assign ir_tdo = ir_sh[0];

   a_r3_ir_capture: assert property (@(posedge tck) disable iff (!trst_n)
      (state == ST_CAP_IR) |=> (ir_sh[1:0] == 2'b01));

endmodule

// File: rtl/dbg_dr_bank.sv
module dbg_dr_bank
   import dbg_scan_pkg::*;
#(
   parameter int              DATA_W     = 32,
   parameter int              ADDR_W     = 2,
   parameter int              ACK_W      = 3,
   parameter int              ID_W       = 32,
   parameter bit              HAS_IDCODE = 1'b1,
   parameter logic [ID_W-1:0] ID_VALUE   = 32'h3BA00477
)(
   input  logic              tck,
   input  logic              trst_n,
   input  tap_state_t        state,
   input  logic              tdi,
   input  logic              sel_id,
   input  logic              sel_dp,
   input  logic              sel_ap,
   input  logic              sel_ab,
   input  logic              port_busy,
   input  logic [DATA_W-1:0] resp_data,
   input  logic [ACK_W-1:0]  resp_ack,
   output logic              dr_tdo,
   output logic              req_valid,
   output logic              req_ap,
   output logic [ADDR_W-1:0] req_addr,
   output logic              req_rnw,
   output logic [DATA_W-1:0] req_data,
   output logic              abort_pulse
);

   localparam int ACC_W  = DATA_W + ADDR_W + 1;
   localparam int DAT_LO = ADDR_W + 1;

   initial begin : p_param_chk
      assert (ACK_W == ADDR_W + 1) else $error("ack field must span address and flag");
      assert (DATA_W >= 2)         else $error("DATA_W too small");
      assert (ID_W >= 2)           else $error("ID_W too small");
   end

   logic             sel_acc;
   logic             byp_q;
   logic [ACC_W-1:0] acc_sh;
   logic             wait_q;
   logic             id_tdo;
   logic             in_cap, in_sh, in_upd;

   assign sel_acc = sel_dp | sel_ap;
   assign in_cap  = (state == ST_CAP_DR);
   assign in_sh   = (state == ST_SH_DR);
   assign in_upd  = (state == ST_UPD_DR);

   // bypass stage
   always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n)    byp_q <= 1'b0;
      else if (in_cap) byp_q <= 1'b0;
      else if (in_sh)  byp_q <= tdi;
   end

   // identification register, present or folded into bypass
   generate
      if (HAS_IDCODE) begin : g_id
         logic [ID_W-1:0] id_sh;
         always_ff @(posedge tck or negedge trst_n) begin
            if (!trst_n)               id_sh <= '0;
            else if (in_cap && sel_id) id_sh <= ID_VALUE;
            else if (in_sh && sel_id)  id_sh <= {tdi, id_sh[ID_W-1:1]};
         end
         assign id_tdo = id_sh[0];

         a_r2_id_capture: assert property (@(posedge tck) disable iff (!trst_n)
            (in_cap && sel_id) |=> (id_sh == ID_VALUE));
      end else begin : g_no_id
         assign id_tdo = byp_q;
      end
   endgenerate

   // shared access / abort register
   always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n) begin
         acc_sh <= '0;
         wait_q <= 1'b0;
      end else if (in_cap && sel_acc) begin
         acc_sh <= {resp_data, (port_busy ? ACK_WAIT : resp_ack)};
         wait_q <= port_busy;
      end else if (in_cap && sel_ab) begin
         acc_sh <= '0;
         wait_q <= 1'b0;
      end else if (in_sh && (sel_acc || sel_ab)) begin
         acc_sh <= {tdi, acc_sh[ACC_W-1:1]};
      end
   end

   always_comb begin
      if (sel_acc || sel_ab) dr_tdo = acc_sh[0];
      else if (sel_id)       dr_tdo = id_tdo;
      else                   dr_tdo = byp_q;
   end

   // request issue on leaving Update-DR
   logic              sh_rnw;
   logic [ADDR_W-1:0] sh_addr;
   logic              dp_reserved_wr;
   logic              issue;

   assign sh_rnw         = acc_sh[0];
   assign sh_addr        = acc_sh[ADDR_W:1];
   assign dp_reserved_wr = sel_dp && !sh_rnw && (sh_addr == '0);
   assign issue          = in_upd && sel_acc && !wait_q && !dp_reserved_wr;

   always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n) begin
         req_valid   <= 1'b0;
         req_ap      <= 1'b0;
         req_addr    <= '0;
         req_rnw     <= 1'b0;
         req_data    <= '0;
         abort_pulse <= 1'b0;
      end else begin
         req_valid   <= issue;
         abort_pulse <= in_upd && sel_ab && acc_sh[0];
         if (issue) begin
            req_ap   <= sel_ap;
            req_addr <= sh_addr;
            req_rnw  <= sh_rnw;
            req_data <= acc_sh[ACC_W-1:DAT_LO];
         end
      end
   end

   a_r5_req_one_cycle: assert property (@(posedge tck) disable iff (!trst_n)
      req_valid |=> !req_valid);

   a_r5_req_after_update: assert property (@(posedge tck) disable iff (!trst_n)
      req_valid |-> ($past(state) == ST_UPD_DR));

   a_r7_busy_captures_wait: assert property (@(posedge tck) disable iff (!trst_n)
      (in_cap && sel_acc && port_busy) |=> (acc_sh[ACK_W-1:0] == ACK_WAIT));

   a_r9_abort_one_cycle: assert property (@(posedge tck) disable iff (!trst_n)
      abort_pulse |=> !abort_pulse);

endmodule

// File: rtl/dbg_scan_port.sv
module dbg_scan_port
   import dbg_scan_pkg::*;
#(
   parameter int          IR_W       = 4,
   parameter int          DATA_W     = 32,
   parameter int          ADDR_W     = 2,
   parameter int          ACK_W      = 3,
   parameter int          ID_W       = 32,
   parameter bit          HAS_IDCODE = 1'b1,
   parameter logic [ID_W-1:0] ID_VALUE = 32'h3BA00477,
   parameter logic [IR_W-1:0] OP_ID    = 4'b1110,
   parameter logic [IR_W-1:0] OP_DP    = 4'b1010,
   parameter logic [IR_W-1:0] OP_AP    = 4'b1011,
   parameter logic [IR_W-1:0] OP_ABORT = 4'b1000
)(
   input  logic              tck,
   input  logic              trst_n,
   input  logic              tms,
   input  logic              tdi,
   output logic              tdo,
   output logic              req_valid,
   output logic              req_ap,
   output logic [ADDR_W-1:0] req_addr,
   output logic              req_rnw,
   output logic [DATA_W-1:0] req_data,
   input  logic              port_busy,
   input  logic [DATA_W-1:0] resp_data,
   input  logic [ACK_W-1:0]  resp_ack,
   output logic              abort_pulse
);

   tap_state_t      state;
   logic [IR_W-1:0] ir;
   logic            ir_tdo, dr_tdo;
   logic            sel_id, sel_dp, sel_ap, sel_ab;

   dbg_tap_fsm u_tap (
      .tck    (tck),
      .trst_n (trst_n),
      .tms    (tms),
      .state  (state)
   );

   dbg_ir_stage #(.IR_W(IR_W), .RESET_OP(OP_ID)) u_ir (
      .tck    (tck),
      .trst_n (trst_n),
      .state  (state),
      .tdi    (tdi),
      .ir     (ir),
      .ir_tdo (ir_tdo)
   );

   // unknown opcodes leave every select low and fall to bypass
   assign sel_id = (ir == OP_ID) && HAS_IDCODE;
   assign sel_dp = (ir == OP_DP);
   assign sel_ap = (ir == OP_AP);
   assign sel_ab = (ir == OP_ABORT);

   dbg_dr_bank #(
      .DATA_W     (DATA_W),
      .ADDR_W     (ADDR_W),
      .ACK_W      (ACK_W),
      .ID_W       (ID_W),
      .HAS_IDCODE (HAS_IDCODE),
      .ID_VALUE   (ID_VALUE)
   ) u_dr (
      .tck         (tck),
      .trst_n      (trst_n),
      .state       (state),
      .tdi         (tdi),
      .sel_id      (sel_id),
      .sel_dp      (sel_dp),
      .sel_ap      (sel_ap),
      .sel_ab      (sel_ab),
      .port_busy   (port_busy),
      .resp_data   (resp_data),
      .resp_ack    (resp_ack),
      .dr_tdo      (dr_tdo),
      .req_valid   (req_valid),
      .req_ap      (req_ap),
      .req_addr    (req_addr),
      .req_rnw     (req_rnw),
      .req_data    (req_data),
      .abort_pulse (abort_pulse)
   );

   // TDO launched on the falling edge
   always_ff @(negedge tck or negedge trst_n) begin
      if (!trst_n)                tdo <= 1'b0;
      else if (state == ST_SH_DR) tdo <= dr_tdo;
      else if (state == ST_SH_IR) tdo <= ir_tdo;
      else                        tdo <= 1'b0;
   end

   a_r10_tdo_idle_low: assert property (@(posedge tck) disable iff (!trst_n)
      (state == ST_RTI && $past(state) == ST_RTI) |-> (tdo == 1'b0));

endmodule

// File: tb/tb_dbg_scan_port.sv
`timescale 1ns/1ps
module tb_dbg_scan_port;

   localparam logic [31:0] IDV = 32'h3BA00477;

   logic        clk = 1'b0;
   logic        trst_n = 1'b0;
   logic        tms = 1'b1;
   logic        tdi = 1'b0;
   logic        tdo;
   logic        req_valid, req_ap, req_rnw, abort_pulse;
   logic [1:0]  req_addr;
   logic [31:0] req_data;
   logic        port_busy = 1'b0;
   logic [31:0] resp_data = '0;
   logic [2:0]  resp_ack  = '0;

   int n_chk = 0;
   int n_bad = 0;

   always #4 clk = ~clk;

   dbg_scan_port dut (
      .tck(clk), .trst_n(trst_n), .tms(tms), .tdi(tdi), .tdo(tdo),
      .req_valid(req_valid), .req_ap(req_ap), .req_addr(req_addr),
      .req_rnw(req_rnw), .req_data(req_data), .port_busy(port_busy),
      .resp_data(resp_data), .resp_ack(resp_ack), .abort_pulse(abort_pulse)
   );

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // one TCK cycle: drive after falling edge, sample TDO just before rising edge
   task automatic step(input logic m, input logic d, output logic t);
      @(negedge clk);
      #1;
      tms = m;
      tdi = d;
      #2;
      t = tdo;
      @(posedge clk);
      #1;
   endtask

   task automatic ir_scan(input logic [3:0] op, output logic [3:0] cap);
      logic t;
      step(1, 0, t); step(1, 0, t); step(0, 0, t); step(0, 0, t);
      for (int k = 0; k < 4; k++) begin
         step(k == 3, op[k], t);
         cap[k] = t;
      end
      step(1, 0, t); step(0, 0, t);
   endtask

   task automatic dr_scan(input int len, input logic [63:0] din, output logic [63:0] dout);
      logic t;
      dout = '0;
      step(1, 0, t); step(0, 0, t); step(0, 0, t);
      for (int k = 0; k < len; k++) begin
         step(k == len - 1, din[k], t);
         dout[k] = t;
      end
      step(1, 0, t); step(0, 0, t);
   endtask

   function automatic int reg_len(input logic [3:0] op);
      case (op)
         4'b1110: return 32;
         4'b1010, 4'b1011, 4'b1000: return 35;
         default: return 1;
      endcase
   endfunction

   initial begin : watchdog
      #(8 * 200000);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin : main
      logic [63:0] d;
      logic [3:0]  c;
      logic        t;
      logic [34:0] w;

      repeat (3) @(posedge clk);
      #1;
      chk("R10 reset tdo", tdo, 0);
      chk("R5 reset req_valid", req_valid, 0);
      chk("R9 reset abort", abort_pulse, 0);
      @(negedge clk);
      trst_n = 1'b1;
      step(0, 0, t);

      // R1/R2: identification selected straight after reset
      dr_scan(32, 64'h0, d);
      chk("R1 R2 idcode after reset", d[31:0], IDV);
      chk("R10 tdo low in idle", tdo, 0);

      // R3: IR capture pattern
      ir_scan(4'b1111, c);
      chk("R3 ir capture", c, 4'b0001);

      // R1: five TMS-high edges from inside Shift-DR
      step(1, 0, t); step(0, 0, t); step(0, 0, t); step(0, 1, t);
      for (int k = 0; k < 5; k++) step(1, 0, t);
      step(0, 0, t);
      dr_scan(32, 64'h0, d);
      chk("R1 tms reset restores idcode", d[31:0], IDV);

      // R4/R2/R5/R9: register length for every opcode
      for (int op = 0; op < 16; op++) begin
         int L, bad;
         logic exp;
         ir_scan(op[3:0], c);
         dr_scan(48, {64{1'b1}}, d);
         L = reg_len(op[3:0]);
         bad = 0;
         for (int k = 0; k < 48; k++) begin
            if (k >= L)       exp = 1'b1;
            else if (L == 32) exp = IDV[k];
            else              exp = 1'b0;
            if (d[k] !== exp) bad++;
         end
         chk($sformatf("R4 length sweep op=%0d", op), bad, 0);
      end

      // R5: debug-port write
      ir_scan(4'b1010, c);
      w = {32'hA5A51234, 2'b10, 1'b0};
      dr_scan(35, {29'b0, w}, d);
      chk("R5 dp write valid", req_valid, 1);
      chk("R5 dp write fields", {req_ap, req_addr, req_rnw, req_data},
          {1'b0, 2'b10, 1'b0, 32'hA5A51234});
      step(0, 0, t);
      chk("R5 strobe one cycle", req_valid, 0);

      // R5: access-port read
      ir_scan(4'b1011, c);
      w = {32'h0000BEEF, 2'b01, 1'b1};
      dr_scan(35, {29'b0, w}, d);
      chk("R5 ap read fields", {req_valid, req_ap, req_addr, req_rnw, req_data},
          {1'b1, 1'b1, 2'b01, 1'b1, 32'h0000BEEF});

      // R6: capture of read result and acknowledge
      resp_data = 32'hDEADBEEF;
      resp_ack  = 3'b010;
      dr_scan(35, {29'b0, 35'h1}, d);
      chk("R6 capture data+ack", d[34:0], {32'hDEADBEEF, 3'b010});

      // R7: busy gives WAIT and no request
      port_busy = 1'b1;
      dr_scan(35, {29'b0, 32'h1, 2'b11, 1'b1}, d);
      chk("R7 wait ack", d[2:0], 3'b001);
      chk("R7 no request when busy", req_valid, 0);
      port_busy = 1'b0;

      // R8: reserved debug-port address
      ir_scan(4'b1010, c);
      dr_scan(35, {29'b0, 32'h55, 2'b00, 1'b0}, d);
      chk("R8 dp write addr0 dropped", req_valid, 0);
      dr_scan(35, {29'b0, 32'h0, 2'b00, 1'b1}, d);
      chk("R8 dp read addr0 forwarded", {req_valid, req_addr, req_rnw}, {1'b1, 2'b00, 1'b1});

      // R9: abort register
      ir_scan(4'b1000, c);
      dr_scan(35, 64'h1, d);
      chk("R9 abort capture zero", d[34:0], 0);
      chk("R9 abort pulse", abort_pulse, 1);
      chk("R9 abort not a request", req_valid, 0);
      step(0, 0, t);
      chk("R9 abort one cycle", abort_pulse, 0);
      dr_scan(35, 64'h0, d);
      chk("R9 no abort bit0 clear", abort_pulse, 0);
      dr_scan(35, 64'h7_0000_0003, d);
      chk("R9 abort with reserved bits", abort_pulse, 1);

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule